// File: doc/BRIEF.md
# DMA Channel Address and Page Generator

This block holds the address and transfer-count state of a single DMA channel and turns it into a full 32-bit physical bus address. Software loads a 16-bit start address and a 16-bit count (programmed as the number of transfers minus one), selects byte or word granularity and optional auto-reload, and writes a low page register and a high page register. Every accepted transfer strobe presents the current bus address, then steps the address counter up by one and the count down by one.

A byte channel places the counter directly under the page bits. A word channel moves 16 bits per transfer, so the counter is shifted up by one bit, bus bit 0 is held at zero and page bit 0 is not used. Normally the counter wraps inside its 64K (byte) or 128K (word) window. Writing the high page register arms carry propagation, so that a counter wrap advances the page. A later write to the low page register alone disarms it. When the count underflows, the block pulses terminal count. It then either reloads the programmed start values (auto-reload) or masks the channel.

Top module: `dma_agen`

## Requirements
- R1: After reset, masked_o is 1, tc_o is 0, count_o is 0 and bus_addr_o is 0.
- R2: In byte mode (word_i=0), bus_addr_o = {high page[7:0], low page[7:0], address counter[15:0]}.
- R3: In word mode (word_i=1), bus_addr_o = {high page[7:0], low page[7:1], address counter[15:0], 1'b0}; low page bit 0 has no effect on the bus address.
- R4: A strobe accepted on a clock edge (xfer_i=1, channel unmasked, no base load) increments the address counter by one and decrements count_o by one, both visible after that edge.
- R5: A strobe while masked_o is 1 changes neither count_o nor bus_addr_o.
- R6: An accepted strobe when count_o is 0 makes tc_o 1 for exactly the following cycle and leaves count_o at 0xFFFF (without auto-reload).
- R7: With auto-reload off, the terminal-count edge sets masked_o to 1.
- R8: With auto-reload on, the terminal-count edge restores the address counter and count_o to the last loaded base values, and the channel stays unmasked.
- R9: With carry disarmed, a step from counter value 0xFFFF wraps the counter to 0 and leaves the page bits unchanged.
- R10: With carry armed, a step from 0xFFFF advances the page field by one: {high, low} page in byte mode, {high, low[7:1]} in word mode, with low bit 0 kept.
- R11: A high page write arms carry. A low page write alone disarms it. When both are written on the same edge, carry ends up armed.
- R12: base_wr_i loads the base and current address and count on the same edge, and it overrides a strobe on that edge.
- R13: mask_set_i sets masked_o and mask_clr_i clears it. If both are asserted together, the channel ends masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_wr_i | input | 1 | Load the base and current address and count |
| base_addr_i | input | 16 | Start address (counter units) |
| base_cnt_i | input | 16 | Transfer count minus one |
| mode_wr_i | input | 1 | Load the mode bits |
| word_i | input | 1 | 1 selects a 16-bit word channel |
| auto_init_i | input | 1 | 1 selects reload at terminal count |
| page_wr_i | input | 1 | Write the low page register and disarm carry |
| page_i | input | 8 | Low page value |
| hipage_wr_i | input | 1 | Write the high page register and arm carry |
| hipage_i | input | 8 | High page value |
| mask_set_i | input | 1 | Mask the channel |
| mask_clr_i | input | 1 | Unmask the channel |
| xfer_i | input | 1 | Transfer strobe |
| bus_addr_o | output | 32 | Physical address of the current transfer |
| count_o | output | 16 | Remaining count minus one |
| tc_o | output | 1 | Terminal count pulse |
| masked_o | output | 1 | Channel mask state |

## Verification
The hardest state to reach is a counter wrap on a word channel with carry armed and page bit 0 set. This case needs the base load, the mode, both page writes in the right order and an unmasked strobe, all lined up at counter value 0xFFFF. Each scenario task programs the registers in that order, so the wrap edge is hit with a single strobe. The final bus address shows whether the carry went into bit 1 of the page field and left bit 0 alone. The ordering rule is exercised by writing the pages in both orders and on the same edge, and by checking for each order whether the wrap carries.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;
  typedef struct packed {
    logic word;
    logic auto_init;
  } xfer_mode_t;
endpackage

// File: rtl/dma_agen_cnt.sv
module dma_agen_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0] base_cnt_i,
  input  logic             step_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] addr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] base_addr_q, base_cnt_q, addr_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      addr_q      <= '0;
      cnt_q       <= '0;
    end else if (load_i) begin
      base_addr_q <= base_addr_i;
      base_cnt_q  <= base_cnt_i;
      addr_q      <= base_addr_i;
      cnt_q       <= base_cnt_i;
    end else if (step_i) begin
      if (reload_i) begin
        addr_q <= base_addr_q;
        cnt_q  <= base_cnt_q;
      end else begin
        addr_q <= addr_q + 1'b1;
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == '0);
  assign wrap_o = &addr_q;
endmodule

// File: rtl/dma_agen_page.sv
module dma_agen_page #(
  parameter int PAGE_W   = 8,
  parameter int HIPAGE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                page_wr_i,
  input  logic [PAGE_W-1:0]   page_i,
  input  logic                hipage_wr_i,
  input  logic [HIPAGE_W-1:0] hipage_i,
  input  logic                carry_i,
  input  logic                word_i,
  output logic [PAGE_W-1:0]   page_o,
  output logic [HIPAGE_W-1:0] hipage_o,
  output logic                carry_en_o
);
  localparam int UP_W = PAGE_W + HIPAGE_W;

  logic [PAGE_W-1:0]   page_q;
  logic [HIPAGE_W-1:0] hipage_q;
  logic                carry_en_q;
  logic [UP_W-1:0]     byte_inc;
  logic [UP_W-2:0]     word_inc;
  logic [UP_W-1:0]     up_nxt;

  assign byte_inc = {hipage_q, page_q} + 1'b1;
  assign word_inc = {hipage_q, page_q[PAGE_W-1:1]} + 1'b1;

  // word channels carry into page bit 1; bit 0 is kept as written
  always_comb begin
    if (word_i) up_nxt = {word_inc, page_q[0]};
    else        up_nxt = byte_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q     <= '0;
      hipage_q   <= '0;
      carry_en_q <= 1'b0;
    end else begin
      if (carry_i && !page_wr_i && !hipage_wr_i) begin
        hipage_q <= up_nxt[UP_W-1:PAGE_W];
        page_q   <= up_nxt[PAGE_W-1:0];
      end else begin
        if (page_wr_i)   page_q   <= page_i;
        if (hipage_wr_i) hipage_q <= hipage_i;
      end
      if (hipage_wr_i)    carry_en_q <= 1'b1;
      else if (page_wr_i) carry_en_q <= 1'b0;
    end
  end

  assign page_o     = page_q;
  assign hipage_o   = hipage_q;
  assign carry_en_o = carry_en_q;
endmodule

// File: rtl/dma_agen_compose.sv
module dma_agen_compose #(
  parameter int CNT_W    = 16,
  parameter int PAGE_W   = 8,
  parameter int HIPAGE_W = 8,
  localparam int BUS_W   = CNT_W + PAGE_W + HIPAGE_W
) (
  input  logic                word_i,
  input  logic [CNT_W-1:0]    addr_i,
  input  logic [PAGE_W-1:0]   page_i,
  input  logic [HIPAGE_W-1:0] hipage_i,
  output logic [BUS_W-1:0]    bus_addr_o
);
  always_comb begin
    if (word_i) bus_addr_o = {hipage_i, page_i[PAGE_W-1:1], addr_i, 1'b0};
    else        bus_addr_o = {hipage_i, page_i, addr_i};
  end
endmodule

// File: rtl/dma_agen.sv
module dma_agen
  import dma_agen_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PAGE_W   = 8,
  parameter int HIPAGE_W = 8,
  localparam int BUS_W   = CNT_W + PAGE_W + HIPAGE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                base_wr_i,
  input  logic [CNT_W-1:0]    base_addr_i,
  input  logic [CNT_W-1:0]    base_cnt_i,
  input  logic                mode_wr_i,
  input  logic                word_i,
  input  logic                auto_init_i,
  input  logic                page_wr_i,
  input  logic [PAGE_W-1:0]   page_i,
  input  logic                hipage_wr_i,
  input  logic [HIPAGE_W-1:0] hipage_i,
  input  logic                mask_set_i,
  input  logic                mask_clr_i,
  input  logic                xfer_i,
  output logic [BUS_W-1:0]    bus_addr_o,
  output logic [CNT_W-1:0]    count_o,
  output logic                tc_o,
  output logic                masked_o
);
  xfer_mode_t       mode_q;
  logic             mask_q, tc_q;
  logic             accept, tc_hit, reload, carry;
  logic             last, wrap, carry_en;
  logic [CNT_W-1:0] addr;
  logic [PAGE_W-1:0]   page;
  logic [HIPAGE_W-1:0] hipage;

  assign accept = xfer_i & ~mask_q & ~base_wr_i;
  assign tc_hit = accept & last;
  assign reload = tc_hit & mode_q.auto_init;
  assign carry  = accept & wrap & carry_en & ~reload;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      mask_q <= 1'b1;
      tc_q   <= 1'b0;
    end else begin
      if (mode_wr_i) begin
        mode_q.word      <= word_i;
        mode_q.auto_init <= auto_init_i;
      end
      if (mask_set_i || (tc_hit && !mode_q.auto_init)) mask_q <= 1'b1;
      else if (mask_clr_i)                             mask_q <= 1'b0;
      tc_q <= tc_hit;
    end
  end

  dma_agen_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (base_wr_i),
    .base_addr_i (base_addr_i),
    .base_cnt_i  (base_cnt_i),
    .step_i      (accept),
    .reload_i    (reload),
    .addr_o      (addr),
    .cnt_o       (count_o),
    .last_o      (last),
    .wrap_o      (wrap)
  );

  dma_agen_page #(.PAGE_W(PAGE_W), .HIPAGE_W(HIPAGE_W)) i_page (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .page_wr_i   (page_wr_i),
    .page_i      (page_i),
    .hipage_wr_i (hipage_wr_i),
    .hipage_i    (hipage_i),
    .carry_i     (carry),
    .word_i      (mode_q.word),
    .page_o      (page),
    .hipage_o    (hipage),
    .carry_en_o  (carry_en)
  );

  dma_agen_compose #(.CNT_W(CNT_W), .PAGE_W(PAGE_W), .HIPAGE_W(HIPAGE_W)) i_compose (
    .word_i     (mode_q.word),
    .addr_i     (addr),
    .page_i     (page),
    .hipage_i   (hipage),
    .bus_addr_o (bus_addr_o)
  );

  assign tc_o     = tc_q;
  assign masked_o = mask_q;
endmodule

// File: rtl/dma_agen_chk.sv
module dma_agen_chk #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             base_wr_i,
  input logic [CNT_W-1:0] base_cnt_i,
  input logic             xfer_i,
  input logic             mask_set_i,
  input logic             mask_clr_i,
  input logic             auto_i,
  input logic [BUS_W-1:0] bus_addr_o,
  input logic [CNT_W-1:0] count_o,
  input logic             tc_o,
  input logic             masked_o
);
  a_r6_tc_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> !tc_o);

  a_r5_masked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_o && xfer_i && !base_wr_i) |=> ($stable(count_o) && $stable(bus_addr_o)));

  a_r4_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!masked_o && xfer_i && !base_wr_i && count_o != '0) |=> (count_o == $past(count_o) - 1'b1));

  a_r7_mask_at_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !$past(auto_i)) |-> masked_o);

  a_r12_base_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_wr_i |=> (count_o == $past(base_cnt_i)));

  a_r13_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_set_i && mask_clr_i) |=> masked_o);
endmodule

bind dma_agen dma_agen_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .base_wr_i  (base_wr_i),
  .base_cnt_i (base_cnt_i),
  .xfer_i     (xfer_i),
  .mask_set_i (mask_set_i),
  .mask_clr_i (mask_clr_i),
  .auto_i     (mode_q.auto_init),
  .bus_addr_o (bus_addr_o),
  .count_o    (count_o),
  .tc_o       (tc_o),
  .masked_o   (masked_o)
);

// File: tb/test_dma_agen.sv
module test_dma_agen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        base_wr = 1'b0, mode_wr = 1'b0, word = 1'b0, auto_init = 1'b0;
  logic        page_wr = 1'b0, hipage_wr = 1'b0, mask_set = 1'b0, mask_clr = 1'b0, xfer = 1'b0;
  logic [15:0] base_addr = '0, base_cnt = '0;
  logic [7:0]  page = '0, hipage = '0;
  logic [31:0] bus_addr;
  logic [15:0] count;
  logic        tc, masked;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_agen i_dma_agen (
    .clk_i(clk), .rst_ni(rst_ni),
    .base_wr_i(base_wr), .base_addr_i(base_addr), .base_cnt_i(base_cnt),
    .mode_wr_i(mode_wr), .word_i(word), .auto_init_i(auto_init),
    .page_wr_i(page_wr), .page_i(page), .hipage_wr_i(hipage_wr), .hipage_i(hipage),
    .mask_set_i(mask_set), .mask_clr_i(mask_clr), .xfer_i(xfer),
    .bus_addr_o(bus_addr), .count_o(count), .tc_o(tc), .masked_o(masked)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one edge, then clear every pulse input at the following falling edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    base_wr = 0; mode_wr = 0; page_wr = 0; hipage_wr = 0;
    mask_set = 0; mask_clr = 0; xfer = 0;
  endtask

  task automatic set_mode(input logic w, input logic a);
    mode_wr = 1; word = w; auto_init = a; cyc();
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] c);
    base_wr = 1; base_addr = a; base_cnt = c; cyc();
  endtask

  task automatic wr_page(input logic [7:0] p);
    page_wr = 1; page = p; cyc();
  endtask

  task automatic wr_hipage(input logic [7:0] h);
    hipage_wr = 1; hipage = h; cyc();
  endtask

  task automatic strobe();
    xfer = 1; cyc();
  endtask

  task automatic unmask();
    mask_clr = 1; cyc();
  endtask

  task automatic t_reset();
    chk("R1 masked", {31'b0, masked}, 32'd1);
    chk("R1 tc", {31'b0, tc}, 32'd0);
    chk("R1 count", {16'b0, count}, 32'd0);
    chk("R1 bus", bus_addr, 32'd0);
  endtask

  task automatic t_byte_step_mask();
    set_mode(0, 0);
    wr_page(8'h56);
    wr_hipage(8'h9A);
    load(16'h1234, 16'h0002);
    chk("R12 count", {16'b0, count}, 32'h2);
    chk("R2 bus", bus_addr, 32'h9A561234);
    unmask();
    strobe();
    chk("R4 bus", bus_addr, 32'h9A561235);
    chk("R4 count", {16'b0, count}, 32'h1);
    mask_set = 1; cyc();
    strobe();
    chk("R5 count", {16'b0, count}, 32'h1);
    chk("R5 bus", bus_addr, 32'h9A561235);
  endtask

  task automatic t_tc_noauto();
    unmask();
    load(16'h0010, 16'h0000);
    strobe();
    chk("R6 tc", {31'b0, tc}, 32'd1);
    chk("R6 count", {16'b0, count}, 32'hFFFF);
    chk("R7 masked", {31'b0, masked}, 32'd1);
    chk("R4 addr", {16'b0, bus_addr[15:0]}, 32'h0011);
    cyc();
    chk("R6 tc drop", {31'b0, tc}, 32'd0);
  endtask

  task automatic t_word_compose();
    set_mode(1, 0);
    wr_page(8'h57);
    wr_hipage(8'h01);
    load(16'h8000, 16'h0005);
    chk("R3 bus", bus_addr, 32'h01570000);
    wr_page(8'h56);
    chk("R3 page bit0", bus_addr, 32'h01570000);
  endtask

  task automatic t_wrap_nocarry();
    set_mode(0, 0);
    wr_hipage(8'h00);
    wr_page(8'h12);
    load(16'hFFFF, 16'h0003);
    unmask();
    chk("R9 pre", bus_addr, 32'h0012FFFF);
    strobe();
    chk("R9 R11 wrap", bus_addr, 32'h00120000);
  endtask

  task automatic t_carry_byte();
    wr_page(8'h12);
    wr_hipage(8'h00);
    load(16'hFFFF, 16'h0003);
    strobe();
    chk("R10 byte carry", bus_addr, 32'h00130000);
    wr_page(8'hFF);
    wr_hipage(8'h07);
    load(16'hFFFF, 16'h0003);
    strobe();
    chk("R10 carry hi", bus_addr, 32'h08000000);
  endtask

  task automatic t_carry_word();
    set_mode(1, 0);
    wr_page(8'h13);
    wr_hipage(8'h00);
    load(16'hFFFF, 16'h0003);
    chk("R3 word pre", bus_addr, 32'h0013FFFE);
    strobe();
    chk("R10 word carry", bus_addr, 32'h00140000);
  endtask

  task automatic t_same_edge();
    set_mode(0, 0);
    page_wr = 1; page = 8'h20; hipage_wr = 1; hipage = 8'h00; cyc();
    load(16'hFFFF, 16'h0003);
    strobe();
    chk("R11 same edge", bus_addr, 32'h00210000);
  endtask

  task automatic t_autoinit();
    set_mode(0, 1);
    load(16'h0100, 16'h0001);
    strobe();
    chk("R4 auto step", {16'b0, count}, 32'h0);
    strobe();
    chk("R8 tc", {31'b0, tc}, 32'd1);
    chk("R8 count", {16'b0, count}, 32'h1);
    chk("R8 addr", {16'b0, bus_addr[15:0]}, 32'h0100);
    chk("R8 unmasked", {31'b0, masked}, 32'd0);
  endtask

  task automatic t_base_priority();
    base_wr = 1; base_addr = 16'h4000; base_cnt = 16'h0009; xfer = 1; cyc();
    chk("R12 count", {16'b0, count}, 32'h9);
    chk("R12 addr", {16'b0, bus_addr[15:0]}, 32'h4000);
  endtask

  task automatic t_mask_ctrl();
    mask_set = 1; mask_clr = 1; cyc();
    chk("R13 both", {31'b0, masked}, 32'd1);
    unmask();
    chk("R13 clear", {31'b0, masked}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_byte_step_mask();
    t_tc_noauto();
    t_word_compose();
    t_wrap_nocarry();
    t_carry_byte();
    t_carry_word();
    t_same_edge();
    t_autoinit();
    t_base_priority();
    t_mask_ctrl();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule